// File: doc/BRIEF.md
# Multi-drop asynchronous serial receiver with dormant wakeup

This block turns an asynchronous NRZ serial line into characters of 8 or 9 data bits. Each character is framed by a low start bit and a high stop bit, and data arrives least significant bit first. Timing comes from a clock enable pulsed at 16 times the bit rate. Each bit is decided by a three-sample majority around the bit centre, and any disagreement among those samples is reported as noise. The block reports a completed character, overrun, framing error, line break, and an idle line that follows traffic.

On a multi-drop link, software can put the receiver to sleep by setting the dormant bit. While the receiver is dormant, it raises no status flags and delivers no characters. Hardware clears the dormant bit in one of two ways, chosen by an input:
- a long idle line, which lets a node skip the rest of a message addressed elsewhere; or
- the arrival of a character whose top data bit is set, which marks an address.

Control is a finite-state machine with five states:
- `ST_HUNT` looks for a falling edge.
- `ST_START` checks the start bit at its centre.
- `ST_DATA` shifts in the data bits.
- `ST_STOP` judges the stop bit and completes the character.
- `ST_WAITHI` holds off after a low stop bit until the line returns high.

Its transitions are:
- HUNT→START when a tick sees the line low.
- START→HUNT when the centre vote is high (a false start).
- START→DATA at the end of the start bit.
- DATA→STOP at the end of the last data bit.
- STOP→HUNT when the stop bit votes high.
- STOP→WAITHI when the stop bit votes low.
- WAITHI→HUNT when a tick sees the line high.

Top module: `sci_wake_rx`

## Requirements
- R1: After reset, `rx_char` is 0, and `rdy`, `idle_flag`, `ovr`, `noise`, `frm_err`, `brk` and `dormant` are all 0.
- R2: With `len9`=0, a frame carries 8 data bits LSB first. On completion, `rx_char` holds {0, data}, `rdy` rises, and `rx_char` stays stable while `rdy` stays set.
- R3: With `len9`=1, a frame carries 9 data bits LSB first, and `rx_char` holds all 9 of them.
- R4: A one-cycle `rd_ack` clears `rdy`, `ovr`, `noise`, `frm_err`, `brk` and `idle_flag`.
- R5: If a character completes while `rdy` is set, `ovr` rises and `rx_char` keeps the earlier character.
- R6: A stop bit voted 0 on a character with any nonzero data bit delivers the character with `rdy`=1 and `frm_err`=1.
- R7: A frame whose data and stop bit are all 0 (a break) sets `brk` and `frm_err`, leaves `rdy` clear, and lets the next start be recognised only after the line has been high.
- R8: Each bit is the majority of ticks 7, 8 and 9 of the bit, counting the tick that first saw the start bit low as tick 1. `noise` is set iff any of those samples in the frame disagree; a flipped sample at any other tick changes nothing.
- R9: A low pulse that is gone by tick 9 of the start bit is discarded, with no character and no flag.
- R10: `idle_flag` rises once a character has been delivered and the line has then stayed high for 10 bit times (`len9`=0) or 11 (`len9`=1). It does not rise right after the stop bit.
- R11: While `dormant` is 1, none of `rdy`, `idle_flag`, `ovr`, `noise`, `frm_err` or `brk` can be raised. This covers framing errors, breaks and idle lines.
- R12: With `wake_addr`=0, `dormant` is cleared once the line has stayed high for 160 ticks (`len9`=0) or 176 ticks (`len9`=1), counted from the later of the last low tick and the write that set it. Characters in between keep it set, and the wakeup raises no `idle_flag`.
- R13: With `wake_addr`=1, `dormant` is cleared only by a character with a high stop bit and its top data bit set (bit 7, or bit 8 when `len9`=1). That character is delivered normally with `rdy`=1, and an idle line does not wake the receiver.
- R14: A cycle with `wake_wr`=1 loads `dormant` with `wake_wd` on the next edge, taking priority over a hardware clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial data line, high when idle |
| os_tick | input | 1 | Enable pulse at 16 times the bit rate |
| len9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_addr | input | 1 | Wakeup method: 1 address mark, 0 idle line |
| wake_wr | input | 1 | Write strobe for the dormant bit |
| wake_wd | input | 1 | Value written to the dormant bit |
| rd_ack | input | 1 | Character read; clears the status flags |
| rx_char | output | 9 | Last delivered character, bit 8 is 0 in 8-bit mode |
| rdy | output | 1 | Character ready |
| idle_flag | output | 1 | Idle line seen after traffic |
| ovr | output | 1 | Overrun |
| noise | output | 1 | Sample disagreement in the delivered character |
| frm_err | output | 1 | Stop bit voted low |
| brk | output | 1 | Break received |
| dormant | output | 1 | Current value of the dormant bit |

## Verification
Most internal faults in this block show up at the ports within a single frame.
- A slip in the tick counter or the bit counter moves the sample point or the bit count. That shows as a wrong `rx_char` or a spurious framing or noise flag at the very next stop bit, which is why every 8-bit value and a spread of 9-bit values are swept.
- A stuck or mis-timed dormant bit shows as a flag or `rdy` while asleep, or as a missed wakeup. The idle thresholds are checked a few ticks on each side, so that an off-by-one bit time is exposed within about 20 clocks.
- A wrong WAITHI or false-start path shows as a phantom character on the frame that follows.

// File: rtl/sci_wake_pkg.sv
package sci_wake_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_WAITHI
    } rx_state_t;
endpackage

// File: rtl/sci_rx_sampler.sv
// Tick counter within a bit and three-sample majority voter around the centre.
module sci_rx_sampler #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    input  logic sync,
    output logic at_mid,
    output logic at_end,
    output logic vote,
    output logic disagree
);
    localparam int CW  = $clog2(OSR) + 1;
    localparam int MID = OSR / 2 + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] idx;
    logic          s_a, s_b;

    assign idx    = cnt + 1'b1;
    assign at_mid = tick && !sync && (idx == CW'(MID));
    assign at_end = tick && !sync && (idx == CW'(OSR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            s_a <= 1'b1;
            s_b <= 1'b1;
        end else if (sync) begin
            cnt <= CW'(1);
        end else if (tick) begin
            cnt <= (idx == CW'(OSR)) ? '0 : idx;
            if (idx == CW'(MID - 2)) s_a <= rxd;
            if (idx == CW'(MID - 1)) s_b <= rxd;
        end
    end

    assign vote     = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
    assign disagree = !((s_a == s_b) && (s_b == rxd));
endmodule

// File: rtl/sci_rx_idle.sv
// Counts ticks of continuous high line; saturates at one character time.
module sci_rx_idle #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    input  logic restart,
    input  logic len9,
    output logic idle_hit
);
    localparam int LW = $clog2(11 * OSR + 1);

    logic [LW-1:0] run;
    logic [LW-1:0] limit;

    assign limit    = len9 ? LW'(11 * OSR) : LW'(10 * OSR);
    assign idle_hit = (run >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run <= '0;
        else if (restart)          run <= '0;
        else if (tick) begin
            if (!rxd)              run <= '0;
            else if (run < limit)  run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/sci_wake_rx.sv
module sci_wake_rx
    import sci_wake_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       os_tick,
    input  logic       len9,
    input  logic       wake_addr,
    input  logic       wake_wr,
    input  logic       wake_wd,
    input  logic       rd_ack,
    output logic [8:0] rx_char,
    output logic       rdy,
    output logic       idle_flag,
    output logic       ovr,
    output logic       noise,
    output logic       frm_err,
    output logic       brk,
    output logic       dormant
);
    rx_state_t  state, nstate;
    logic       sync, at_mid, at_end, vote, disagree, idle_hit;
    logic [3:0] bitn, last_bit;
    logic [8:0] sh, char_now;
    logic       nacc, armed, done, is_break, wake_by_mark, live, rdy_eff;

    assign sync = (state == ST_HUNT) && os_tick && !rxd;

    sci_rx_sampler #(.OSR(OSR)) u_smp (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd), .sync(sync),
        .at_mid(at_mid), .at_end(at_end), .vote(vote), .disagree(disagree)
    );

    sci_rx_idle #(.OSR(OSR)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd),
        .restart(wake_wr), .len9(len9), .idle_hit(idle_hit)
    );

    assign last_bit     = len9 ? 4'd8 : 4'd7;
    assign char_now     = len9 ? sh : {1'b0, sh[8:1]};
    assign done         = (state == ST_STOP) && at_mid;
    assign is_break     = !vote && (char_now == 9'd0);
    assign wake_by_mark = dormant && wake_addr && done && vote && sh[8];
    assign live         = !dormant || wake_by_mark;
    assign rdy_eff      = rdy && !rd_ack;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nstate;
    end

    // Next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_HUNT:   if (sync) nstate = ST_START;
            ST_START:  if (at_mid && vote) nstate = ST_HUNT;
                       else if (at_end)    nstate = ST_DATA;
            ST_DATA:   if (at_end && bitn == last_bit) nstate = ST_STOP;
            ST_STOP:   if (at_mid) nstate = vote ? ST_HUNT : ST_WAITHI;
            ST_WAITHI: if (os_tick && rxd) nstate = ST_HUNT;
            default:   nstate = ST_HUNT;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_char <= '0; rdy <= 1'b0; idle_flag <= 1'b0; ovr <= 1'b0;
            noise <= 1'b0; frm_err <= 1'b0; brk <= 1'b0; dormant <= 1'b0;
            bitn <= '0; sh <= '0; nacc <= 1'b0; armed <= 1'b0;
        end else begin
            if (rd_ack) begin
                rdy <= 1'b0; ovr <= 1'b0; noise <= 1'b0;
                frm_err <= 1'b0; brk <= 1'b0; idle_flag <= 1'b0;
            end
            if (sync)
                nacc <= 1'b0;
            else if (at_mid && (state == ST_START || state == ST_DATA))
                nacc <= nacc | disagree;
            if (state == ST_START)
                bitn <= '0;
            else if (state == ST_DATA && at_end)
                bitn <= bitn + 1'b1;
            if (state == ST_DATA && at_mid)
                sh <= {vote, sh[8:1]};
            if (done && live) begin
                if (is_break) begin
                    brk <= 1'b1;
                    frm_err <= 1'b1;
                end else if (rdy_eff) begin
                    ovr <= 1'b1;
                end else begin
                    rx_char <= char_now;
                    rdy     <= 1'b1;
                    noise   <= nacc | disagree;
                    frm_err <= !vote;
                end
                armed <= 1'b1;
            end
            if (armed && idle_hit && !dormant) begin
                idle_flag <= 1'b1;
                armed     <= 1'b0;
            end
            if (wake_wr) begin
                dormant <= wake_wd;
                armed   <= 1'b0;
            end else if (dormant && ((!wake_addr && idle_hit) || wake_by_mark)) begin
                dormant <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sci_wake_rx_chk.sv
module sci_wake_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_wr,
    input logic       wake_wd,
    input logic       rd_ack,
    input logic [8:0] rx_char,
    input logic       rdy,
    input logic       idle_flag,
    input logic       ovr,
    input logic       brk,
    input logic       dormant
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && $past(rdy) && !$past(rd_ack)) |-> $stable(rx_char));

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !ovr);

    p_ovr_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(rx_char));

    p_brk_no_char_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk) |-> !$rose(rdy));

    p_idle_awake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> !$past(dormant));

    p_rdy_awake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> (!dormant || $past(wake_wr)));

    p_sw_write_r14: assert property (@(posedge clk) disable iff (!rst_n)
        wake_wr |=> (dormant == $past(wake_wd)));
endmodule

bind sci_wake_rx sci_wake_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wake_wr(wake_wr), .wake_wd(wake_wd),
    .rd_ack(rd_ack), .rx_char(rx_char), .rdy(rdy), .idle_flag(idle_flag),
    .ovr(ovr), .brk(brk), .dormant(dormant)
);

// File: tb/sci_wake_rx_tb.sv
module sci_wake_rx_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, os_tick = 1'b1;
    logic       len9 = 1'b0, wake_addr = 1'b0, wake_wr = 1'b0, wake_wd = 1'b0, rd_ack = 1'b0;
    logic [8:0] rx_char;
    logic       rdy, idle_flag, ovr, noise, frm_err, brk, dormant;
    int         n_chk = 0, n_err = 0;

    always #(CLK_P / 2) clk = ~clk;

    sci_wake_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick), .len9(len9),
        .wake_addr(wake_addr), .wake_wr(wake_wr), .wake_wd(wake_wd), .rd_ack(rd_ack),
        .rx_char(rx_char), .rdy(rdy), .idle_flag(idle_flag), .ovr(ovr),
        .noise(noise), .frm_err(frm_err), .brk(brk), .dormant(dormant)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bit of 16 ticks; sample number g (1..16) is inverted, 0 = none.
    task automatic send_bit(input logic v, input int g);
        for (int k = 1; k <= 16; k++) begin
            rxd = (k == g) ? ~v : v;
            @(negedge clk);
        end
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1, 0);
    endtask

    // gb: 0 start, 1..nb data, nb+1 stop; gp: glitch sample
    task automatic send_frame(input logic [8:0] d, input int nb, input logic stopv,
                              input int gb, input int gp);
        send_bit(1'b0, (gb == 0) ? gp : 0);
        for (int i = 0; i < nb; i++) send_bit(d[i], (gb == i + 1) ? gp : 0);
        send_bit(stopv, (gb == nb + 1) ? gp : 0);
    endtask

    task automatic ack();
        rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
    endtask

    task automatic wake_write(input logic v);
        wake_wr = 1'b1; wake_wd = v; @(negedge clk); wake_wr = 1'b0; wake_wd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        wait_cyc(190000);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_char", int'(rx_char), 0);
        chk("R1 flags", int'({rdy, idle_flag, ovr, noise, frm_err, brk, dormant}), 0);

        // R2 exhaustive 8-bit sweep
        for (int v = 0; v < 256; v++) begin
            send_frame(9'(v), 8, 1'b1, -1, 0);
            idle_bits(1);
            chk("R2 rdy", int'(rdy), 1);
            chk("R2 data", int'(rx_char), v);
            chk("R2 clean", int'({ovr, noise, frm_err, brk}), 0);
            ack();
            chk("R4 ack clears rdy", int'(rdy), 0);
        end

        // R3 9-bit spread
        len9 = 1'b1;
        for (int k = 0; k < 64; k++) begin
            send_frame(9'((k * 37 + 3) & 9'h1FF), 9, 1'b1, -1, 0);
            idle_bits(1);
            chk("R3 rdy", int'(rdy), 1);
            chk("R3 data", int'(rx_char), (k * 37 + 3) & 9'h1FF);
            ack();
        end
        len9 = 1'b0;

        // R5 overrun keeps first character
        send_frame(9'h0A5, 8, 1'b1, -1, 0);
        idle_bits(1);
        send_frame(9'h03C, 8, 1'b1, -1, 0);
        idle_bits(1);
        chk("R5 ovr", int'(ovr), 1);
        chk("R5 data kept", int'(rx_char), 9'h0A5);
        chk("R5 rdy", int'(rdy), 1);
        ack();
        chk("R4 ack clears ovr", int'(ovr), 0);

        // R6 framing error
        send_frame(9'h03C, 8, 1'b0, -1, 0);
        idle_bits(1);
        chk("R6 frm_err", int'(frm_err), 1);
        chk("R6 rdy", int'(rdy), 1);
        chk("R6 data", int'(rx_char), 9'h03C);
        ack();
        chk("R4 ack clears frm_err", int'(frm_err), 0);

        // R7 break, longer than a frame, then a normal frame
        for (int i = 0; i < 14; i++) send_bit(1'b0, 0);
        idle_bits(1);
        chk("R7 brk", int'(brk), 1);
        chk("R7 frm_err", int'(frm_err), 1);
        chk("R7 no rdy", int'(rdy), 0);
        ack();
        chk("R4 ack clears brk", int'(brk), 0);
        send_frame(9'h05A, 8, 1'b1, -1, 0);
        idle_bits(1);
        chk("R7 next frame rdy", int'(rdy), 1);
        chk("R7 next frame data", int'(rx_char), 9'h05A);
        ack();

        // R8 glitch sweep over data bit 3 (value 0x55 -> bit3 = 0)
        for (int p = 1; p <= 16; p++) begin
            send_frame(9'h055, 8, 1'b1, 4, p);
            idle_bits(1);
            chk("R8 noise", int'(noise), (p >= 7 && p <= 9) ? 1 : 0);
            chk("R8 data", int'(rx_char), 9'h055);
            ack();
            chk("R4 ack clears noise", int'(noise), 0);
        end

        // R9 false start
        for (int k = 1; k <= 5; k++) begin rxd = 1'b0; @(negedge clk); end
        rxd = 1'b1;
        idle_bits(12);
        chk("R9 no char", int'({rdy, frm_err, noise, brk}), 0);
        send_frame(9'h081, 8, 1'b1, -1, 0);
        idle_bits(1);
        chk("R9 later frame", int'(rx_char), 9'h081);
        ack();

        // R10 idle flag after traffic
        send_frame(9'h041, 8, 1'b1, -1, 0);
        idle_bits(1);
        chk("R10 not yet", int'(idle_flag), 0);
        idle_bits(10);
        chk("R10 idle", int'(idle_flag), 1);
        ack();
        chk("R4 ack clears idle", int'(idle_flag), 0);
        idle_bits(12);
        chk("R10 once per traffic", int'(idle_flag), 0);

        // R14 software write
        wake_addr = 1'b1;
        wake_write(1'b1);
        chk("R14 set", int'(dormant), 1);
        wake_write(1'b0);
        chk("R14 clear", int'(dormant), 0);

        // R11 / R13 address-mark, 8-bit
        wake_write(1'b1);
        send_frame(9'h012, 8, 1'b1, -1, 0);
        idle_bits(1);
        chk("R11 no rdy", int'(rdy), 0);
        chk("R13 still dormant", int'(dormant), 1);
        send_frame(9'h005, 8, 1'b0, -1, 0);
        idle_bits(1);
        chk("R11 no frm_err", int'({frm_err, rdy}), 0);
        for (int i = 0; i < 12; i++) send_bit(1'b0, 0);
        idle_bits(14);
        chk("R11 no brk/idle", int'({brk, idle_flag, ovr, noise}), 0);
        chk("R13 idle does not wake", int'(dormant), 1);
        send_frame(9'h093, 8, 1'b1, -1, 0);
        idle_bits(1);
        chk("R13 woken", int'(dormant), 0);
        chk("R13 rdy", int'(rdy), 1);
        chk("R13 data", int'(rx_char), 9'h093);
        ack();

        // R13 address-mark, 9-bit
        len9 = 1'b1;
        wake_write(1'b1);
        send_frame(9'h0FF, 9, 1'b1, -1, 0);
        idle_bits(1);
        chk("R13 bit7 no mark in 9-bit", int'({dormant, rdy}), 2);
        send_frame(9'h101, 9, 1'b1, -1, 0);
        idle_bits(1);
        chk("R13 9-bit woken", int'(dormant), 0);
        chk("R13 9-bit data", int'(rx_char), 9'h101);
        ack();

        // R12 idle-line wakeup
        wake_addr = 1'b0;
        len9 = 1'b0;
        wake_write(1'b1);
        wait_cyc(150);
        chk("R12 8-bit before limit", int'(dormant), 1);
        wait_cyc(20);
        chk("R12 8-bit woken", int'(dormant), 0);
        chk("R12 no idle flag", int'(idle_flag), 0);
        wake_write(1'b1);
        for (int f = 0; f < 3; f++) send_frame(9'h0F0, 8, 1'b1, -1, 0);
        idle_bits(1);
        chk("R12 traffic keeps dormant", int'({dormant, rdy}), 2);
        idle_bits(11);
        chk("R12 woken after idle", int'(dormant), 0);
        send_frame(9'h03C, 8, 1'b1, -1, 0);
        idle_bits(1);
        chk("R12 receives after wake", int'(rx_char), 9'h03C);
        ack();
        len9 = 1'b1;
        wake_write(1'b1);
        wait_cyc(168);
        chk("R12 9-bit before limit", int'(dormant), 1);
        wait_cyc(20);
        chk("R12 9-bit woken", int'(dormant), 0);

        finish_run();
    end
endmodule